// File: doc/BRIEF.md
# Burst Serial Port with Byte Buffer

This block is a clock-synchronous serial port that moves a burst of one to eight bytes without processor help. Software loads outgoing bytes into an eight-slot byte buffer, programs the burst length and starts the transfer. The port shifts each slot out most significant bit first and overwrites that same slot with the byte received during it. When the last byte finishes, the port raises a single-cycle completion pulse, and software reads the received bytes back from slot 0 onward.

The serial clock is either generated inside the block, with a programmable half period counted in system clocks, or taken from an external master through a two-stage synchronizer. An optional gated mode ties the transfer to an active-low select line. While the select line is high, the clock and data outputs are released (their enables drop) and no bit moves. Raising the select line part way through a byte aborts the burst and sets a sticky error flag.

Top module: `csync_burst_port`

## Requirements
- R1: After reset the port is idle: `busy`, `done_irq` and `err` are 0 and `sck_out` is 1.
- R2: While idle, each `wr_en` stores `wr_data` in the next slot and each `rd_en` advances the read slot, with `rd_data` showing the current read slot. Both slot pointers return to slot 0 when a burst starts, and they stay there until the burst ends.
- R3: A `start` while idle runs a burst of `cnt_m1`+1 bytes, from 1 to 8, taken from slots 0 upward. Each byte goes out on `so` with the most significant bit first.
- R4: The serial clock idles high. `so` changes after a falling edge, and `si` is sampled on a rising edge.
- R5: The byte received during a slot's transfer replaces that slot. It can be read back after the burst.
- R6: With `master`=1, every high and low phase of `sck_out` lasts HALF_DIV system clocks (8 by default).
- R7: With `master`=0 the bit timing follows `sck_in`. `sck_oe` is 0 and `sck_out` stays 1.
- R8: `done_irq` is 1 for exactly one cycle per completed burst, and `busy` is already 0 in that cycle.
- R9: With `cs_mode`=1, `sck_oe` and `so_oe` are 0 while `cs_n` is 1, and no clock edge occurs. Otherwise `so_oe` is 1 and `sck_oe` equals `master`.
- R10: With `cs_mode`=1, raising `cs_n` after a byte has begun shifting ends the burst with no `done_irq`, and sets `err`. `err` stays set until the next accepted `start`.
- R11: `wr_en`, `rd_en` and `start` have no effect while `busy` is 1, or in the cycle of an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store wr_data in the next slot |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Advance the read slot |
| rd_data | output | 8 | Byte in the current read slot |
| start | input | 1 | Begin a burst |
| cnt_m1 | input | log2(DEPTH) | Burst length minus one |
| master | input | 1 | 1: generate the serial clock, 0: follow sck_in |
| cs_mode | input | 1 | 1: transfer gated by cs_n |
| cs_n | input | 1 | Active-low select |
| sck_in | input | 1 | External serial clock |
| si | input | 1 | Serial data in |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| busy | output | 1 | Burst in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Burst aborted by select |

## Verification
A wrong slot index or bit count shows up at the pins within one byte time. Outgoing bytes arrive shifted or from the wrong slot, and the read-back after the burst shows received bytes in the wrong place. A divider fault changes the spacing of `sck_out` edges at the very next edge. A fault in the gating or abort logic shows as clock edges or a completion pulse while `cs_n` is high, or as `err` failing to rise within two cycles of the select line rising.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/burst_ram.sv
module burst_ram
  import burst_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  byte_t            wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output byte_t            rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output byte_t            rdata_b
);
  byte_t slot_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && (waddr == IDX_W'(i))) slot_q[i] <= wdata;
    end
  end

  assign rdata_a = slot_q[raddr_a];
  assign rdata_b = slot_q[raddr_b];
endmodule

// File: rtl/burst_sck.sv
module burst_sck #(
  parameter int HALF_DIV = 8,
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic active,
  input  logic run,
  input  logic sck_in,
  output logic sck_q,
  output logic rise_evt,
  output logic fall_evt
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             sck_d;
  logic [2:0]       sync_q;
  logic             div_top, m_tick;

  assign div_top = (div_q == DIV_W'(HALF_DIV - 1));
  assign m_tick  = master && run && div_top;

  always_comb begin
    div_d = div_q;
    sck_d = sck_q;
    if (!active) begin
      div_d = '0;
      sck_d = 1'b1;
    end else if (master && run) begin
      if (div_top) begin
        div_d = '0;
        sck_d = ~sck_q;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      div_q  <= div_d;
      sck_q  <= sck_d;
      sync_q <= {sync_q[1:0], sck_in};
    end
  end

  assign rise_evt = master ? (m_tick && !sck_q)
                           : (run && sync_q[1] && !sync_q[2]);
  assign fall_evt = master ? (m_tick && sck_q)
                           : (run && !sync_q[1] && sync_q[2]);

  // R6: a generated clock changes level only when the divider reaches its top
  a_r6_toggle_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master) && $past(active) && (sck_q != $past(sck_q)))
      |-> ($past(div_q) == DIV_W'(HALF_DIV - 1)));

  // R4: the serial clock is high again one cycle after the port goes inactive
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> sck_q);
endmodule

// File: rtl/burst_engine.sv
module burst_engine
  import burst_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cnt_m1,
  input  logic             cs_mode,
  input  logic             cs_n,
  input  logic             si,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  byte_t            slot_rd,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output byte_t            wb_data,
  output logic             so,
  output logic             busy,
  output logic             done_irq,
  output logic             err,
  output logic             stop_now
);
  eng_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             in_byte_q, in_byte_d;
  byte_t            tx_q, tx_d, rx_q, rx_d, rx_next;
  logic             so_q, so_d, done_q, done_d, err_q, err_d;
  logic             abort, finish;

  assign rx_next = {rx_q[BYTE_W-2:0], si};
  assign abort   = (state_q == ST_SHIFT) && cs_mode && cs_n && in_byte_q;
  assign finish  = (state_q == ST_SHIFT) && rise_evt &&
                   (bit_q == BIT_W'(BYTE_W - 1)) && (idx_q == last_q);
  assign rd_idx  = (state_q == ST_SHIFT) ? idx_q + 1'b1 : '0;
  assign wb_idx  = idx_q;
  assign wb_data = rx_next;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    last_d    = last_q;
    bit_d     = bit_q;
    in_byte_d = in_byte_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    so_d      = so_q;
    err_d     = err_q;
    done_d    = 1'b0;
    wb_en     = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        state_d   = ST_SHIFT;
        idx_d     = '0;
        last_d    = cnt_m1;
        bit_d     = '0;
        in_byte_d = 1'b0;
        tx_d      = slot_rd;
        err_d     = 1'b0;
      end
    end else if (abort) begin
      state_d   = ST_IDLE;
      in_byte_d = 1'b0;
      err_d     = 1'b1;
    end else begin
      if (fall_evt) begin
        so_d      = tx_q[BYTE_W-1];
        tx_d      = {tx_q[BYTE_W-2:0], 1'b0};
        in_byte_d = 1'b1;
      end
      if (rise_evt) begin
        rx_d  = rx_next;
        bit_d = bit_q + 1'b1;
        if (bit_q == BIT_W'(BYTE_W - 1)) begin
          wb_en     = 1'b1;
          in_byte_d = 1'b0;
          if (idx_q == last_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
            tx_d  = slot_rd;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      last_q    <= '0;
      bit_q     <= '0;
      in_byte_q <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      so_q      <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      last_q    <= last_d;
      bit_q     <= bit_d;
      in_byte_q <= in_byte_d;
      tx_q      <= tx_d;
      rx_q      <= rx_d;
      so_q      <= so_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign so       = so_q;
  assign busy     = (state_q == ST_SHIFT);
  assign done_irq = done_q;
  assign err      = err_q;
  assign stop_now = abort || finish;

  // R8: completion pulse lasts one cycle and is seen with the port idle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  // R10: the error flag rises only as the burst ends
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (state_q == ST_IDLE));
  // R9: while the select line is released between bytes, no bit moves
  a_r9_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SHIFT) && cs_mode && cs_n && !in_byte_q)
      |=> ($stable(idx_q) && $stable(bit_q)));
  // R3: the slot index never passes the programmed last slot
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (idx_q <= last_q));
endmodule

// File: rtl/csync_burst_port.sv
module csync_burst_port
  import burst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HALF_DIV = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             start,
  input  logic [IDX_W-1:0] cnt_m1,
  input  logic             master,
  input  logic             cs_mode,
  input  logic             cs_n,
  input  logic             sck_in,
  input  logic             si,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             so,
  output logic             so_oe,
  output logic             busy,
  output logic             done_irq,
  output logic             err
);
  logic [1:0]       rsync_q;
  logic             rst_core_n;
  logic [IDX_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [IDX_W-1:0] eng_rd_idx, wb_idx, ram_waddr;
  logic             wb_en, ram_we, cpu_wr_ok, cpu_rd_ok;
  logic             cs_ok, run, active, stop_now, rise_evt, fall_evt, sck_q;
  byte_t            wb_data, eng_slot, ram_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign cs_ok     = !cs_mode || !cs_n;
  assign run       = busy && cs_ok;
  assign active    = busy && !stop_now;
  assign cpu_wr_ok = wr_en && !busy && !start;
  assign cpu_rd_ok = rd_en && !busy && !start;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (!busy) begin
      if (start) begin
        wr_ptr_d = '0;
        rd_ptr_d = '0;
      end else begin
        if (cpu_wr_ok) wr_ptr_d = wr_ptr_q + 1'b1;
        if (cpu_rd_ok) rd_ptr_d = rd_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  assign ram_we    = wb_en || cpu_wr_ok;
  assign ram_waddr = wb_en ? wb_idx : wr_ptr_q;
  assign ram_wdata = wb_en ? wb_data : byte_t'(wr_data);

  burst_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(rd_ptr_q), .rdata_a(rd_data),
    .raddr_b(eng_rd_idx), .rdata_b(eng_slot)
  );

  burst_sck #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk(clk), .rst_n(rst_core_n), .master(master), .active(active),
    .run(run), .sck_in(sck_in), .sck_q(sck_q),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  burst_engine #(.DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .start(start), .cnt_m1(cnt_m1),
    .cs_mode(cs_mode), .cs_n(cs_n), .si(si),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .slot_rd(eng_slot),
    .rd_idx(eng_rd_idx), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .so(so), .busy(busy), .done_irq(done_irq), .err(err), .stop_now(stop_now)
  );

  assign sck_out = sck_q;
  assign sck_oe  = master && cs_ok;
  assign so_oe   = cs_ok;

  // R11: processor access leaves the slot pointers alone during a burst
  a_r11_wr_ignored: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && wr_en) |=> $stable(wr_ptr_q));
  a_r11_rd_ignored: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && rd_en) |=> $stable(rd_ptr_q));
  // R2: pointers sit at slot 0 for the whole burst
  a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |-> (wr_ptr_q == '0 && rd_ptr_q == '0));
endmodule

// File: tb/csync_burst_port_test.sv
module csync_burst_port_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en, start, master, cs_mode, cs_n, sck_in, si;
  logic [7:0] wr_data, rd_data;
  logic [2:0] cnt_m1;
  logic       sck_out, sck_oe, so, so_oe, busy, done_irq, err;

  int checks = 0, fails = 0, done_seen = 0;
  bit prev_done = 0, finished = 0;

  always #5 clk = ~clk;

  csync_burst_port #(.DEPTH(8), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .start(start), .cnt_m1(cnt_m1),
    .master(master), .cs_mode(cs_mode), .cs_n(cs_n), .sck_in(sck_in),
    .si(si), .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .so_oe(so_oe),
    .busy(busy), .done_irq(done_irq), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // R9 R7: enables are a function of the mode pins, compared every clock
  always @(posedge clk) if (rst_n) begin
    chk(sck_oe === (master && (!cs_mode || !cs_n)), "R9 R7 sck_oe", sck_oe,
        master && (!cs_mode || !cs_n));
    chk(so_oe === (!cs_mode || !cs_n), "R9 so_oe", so_oe, !cs_mode || !cs_n);
  end

  // R8: each completion pulse is one cycle wide and seen with busy low
  always @(negedge clk) if (rst_n) begin
    if (done_irq) begin
      done_seen++;
      chk(!busy, "R8 busy with done", busy, 0);
      chk(!prev_done, "R8 done width", 2, 1);
    end
    prev_done = done_irq;
  end

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk) wr_en = 1; wr_data = b;
    @(negedge clk) wr_en = 0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk) b = rd_data; rd_en = 1;
    @(negedge clk) rd_en = 0;
  endtask

  task automatic go(input int n);
    @(negedge clk) cnt_m1 = 3'(n - 1); start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic master_run(input logic [7:0] sib[$], output logic [7:0] sob[$],
                            input bit poke);
    int k = 0, t = 0, last_t = -1, base = done_seen;
    bit prev = 1;
    logic [7:0] cur = 0;
    sob.delete();
    while (done_seen == base && t < 4000) begin
      @(negedge clk); t++;
      if (poke && t == 30) begin wr_en = 1; wr_data = 8'hEE; rd_en = 1; start = 1; end
      else if (poke && t == 31) begin wr_en = 0; rd_en = 0; start = 0; end
      if (sck_out != prev) begin
        if (last_t >= 0) chk(t - last_t == HALF, "R6 half period", t - last_t, HALF);
        last_t = t;
      end
      if (prev && !sck_out && (k / 8) < sib.size()) si = sib[k/8][7 - (k % 8)];
      if (!prev && sck_out) begin
        cur = {cur[6:0], so}; k++;
        if (k % 8 == 0) sob.push_back(cur);
      end
      prev = sck_out;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic slave_run(input logic [7:0] sib[$], output logic [7:0] sob[$]);
    logic [7:0] cur;
    sob.delete();
    foreach (sib[j]) begin
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk) sck_in = 0; si = sib[j][b];
        repeat (HALF) @(negedge clk);
        chk(sck_out === 1'b1, "R7 sck_out held", sck_out, 1);
        cur = {cur[6:0], so};
        sck_in = 1;
        repeat (HALF - 1) @(negedge clk);
      end
      sob.push_back(cur);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic compare(input string req, input logic [7:0] got[$], input logic [7:0] exp[$]);
    chk(got.size() == exp.size(), {req, " count"}, got.size(), exp.size());
    foreach (exp[i]) if (i < got.size()) chk(got[i] === exp[i], req, got[i], exp[i]);
  endtask

  task automatic readback(input logic [7:0] exp[$]);
    logic [7:0] got[$];
    logic [7:0] b;
    foreach (exp[i]) begin rd_byte(b); got.push_back(b); end
    compare("R5 readback", got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] tx[$], rx[$], got[$], b;
    int base;
    rst_n = 0; wr_en = 0; rd_en = 0; start = 0; wr_data = 0; cnt_m1 = 0;
    master = 1; cs_mode = 0; cs_n = 1; sck_in = 1; si = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy === 0, "R1 busy", busy, 0);
    chk(done_irq === 0, "R1 done", done_irq, 0);
    chk(err === 0, "R1 err", err, 0);
    chk(sck_out === 1, "R1 sck_out", sck_out, 1);

    // R2 slots fill and drain in order while idle
    tx = '{8'hA1, 8'hB2, 8'hC3};
    foreach (tx[i]) wr_byte(tx[i]);
    got.delete();
    foreach (tx[i]) begin rd_byte(b); got.push_back(b); end
    compare("R2 idle order", got, tx);

    // R3 R4 R5: master, six bytes; slots 3..5 follow the earlier three
    foreach (tx[i]) ;
    wr_byte(8'h44); wr_byte(8'h55); wr_byte(8'h66);
    tx = '{8'hA1, 8'hB2, 8'hC3, 8'h44, 8'h55, 8'h66};
    rx = '{8'h5A, 8'hC3, 8'h0F, 8'hF0, 8'h81, 8'h7E};
    base = done_seen;
    go(6);
    master_run(rx, got, 0);
    compare("R3 R4 master so", got, tx);
    chk(done_seen == base + 1, "R8 one done", done_seen - base, 1);
    readback(rx);

    // R3 boundary: eight bytes
    tx = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C, 8'hC3, 8'h96, 8'h69};
    rx = '{8'hFE, 8'h7F, 8'h00, 8'hFF, 8'hAA, 8'h55, 8'h12, 8'h34};
    foreach (tx[i]) wr_byte(tx[i]);
    go(8);
    master_run(rx, got, 0);
    compare("R3 eight bytes", got, tx);
    readback(rx);

    // R3 boundary: single byte
    tx = '{8'h9D}; rx = '{8'h62};
    wr_byte(tx[0]);
    go(1);
    master_run(rx, got, 0);
    compare("R3 one byte", got, tx);
    readback(rx);

    // R7 slave mode
    master = 0;
    tx = '{8'hE7, 8'h18}; rx = '{8'hB4, 8'h4B};
    foreach (tx[i]) wr_byte(tx[i]);
    base = done_seen;
    go(2);
    slave_run(rx, got);
    compare("R7 slave so", got, tx);
    chk(done_seen == base + 1, "R7 slave done", done_seen - base, 1);
    chk(busy === 0, "R7 idle after", busy, 0);
    readback(rx);
    master = 1;

    // R9 gated: nothing moves while select is high
    cs_mode = 1; cs_n = 1;
    tx = '{8'hC5}; rx = '{8'h3A};
    wr_byte(tx[0]);
    go(1);
    repeat (40) begin
      @(negedge clk);
      if (sck_out !== 1) break;
    end
    chk(sck_out === 1, "R9 no clock while released", sck_out, 1);
    chk(busy === 1, "R9 still busy", busy, 1);
    @(negedge clk) cs_n = 0;
    master_run(rx, got, 0);
    compare("R9 after select", got, tx);
    readback(rx);

    // R10 abort mid-byte
    wr_byte(8'h11); wr_byte(8'h22);
    base = done_seen;
    go(2);
    repeat (20) @(negedge clk);
    cs_n = 1;
    repeat (2) @(negedge clk);
    chk(busy === 0, "R10 busy after abort", busy, 0);
    chk(err === 1, "R10 err set", err, 1);
    chk(done_seen == base, "R10 no done", done_seen - base, 0);
    repeat (5) @(negedge clk);
    chk(err === 1, "R10 err sticky", err, 1);
    cs_n = 0;
    tx = '{8'h77}; rx = '{8'hD2};
    wr_byte(tx[0]);
    go(1);
    chk(err === 0, "R10 err cleared by start", err, 0);
    master_run(rx, got, 0);
    compare("R10 burst after abort", got, tx);
    readback(rx);
    cs_mode = 0; cs_n = 1;

    // R11 access during a burst is ignored
    tx = '{8'h2B, 8'hB2}; rx = '{8'h4D, 8'hD4};
    foreach (tx[i]) wr_byte(tx[i]);
    base = done_seen;
    go(2);
    master_run(rx, got, 1);
    compare("R11 so unaffected", got, tx);
    repeat (30) @(negedge clk);
    chk(busy === 0, "R11 start ignored", busy, 0);
    chk(done_seen == base + 1, "R11 single done", done_seen - base, 1);
    readback(rx);

    report();
  end
endmodule